// File: doc/BRIEF.md
# I2C Master-Receive Byte Sequencer

This block is the master-receive side of an I2C controller that software drives one byte at a time. Software asks for a START. The block generates it and then stops. Software loads a 7-bit target address and a direction bit into the data register and clears the interrupt flag. The block shifts that byte out and samples the acknowledge, then stops again. After that, each clear of the flag receives one byte, and the block answers it with ACK or NACK according to the acknowledge-enable bit. A STOP request or a repeated-START request ends or restarts the transfer.

Each bus event sets the interrupt flag and posts a fixed 8-bit status code. While the flag is set, the block holds SCL low, so the bus waits for software. The block drives the bus through two open-drain enables: a high output pulls the line low. SCL timing comes from a fixed divider (`QDIV` clock cycles per quarter bit). The block reads SDA back during the address so that it can detect a lost bit and report it. An address sent with the write bit only switches a mode output and reports its own status codes. Byte transmission belongs to another unit.

Top module: `i2c_mrx_seq`

## Requirements
- R1: After reset, ctl_q = 00H, dat_q = 00H, sta_q = F8H, and irq, scl_oe, sda_oe and tx_mode are all 0.
- R2: The control register bits are, MSB to LSB: rate2, enable, start, stop, flag, ack-enable, rate1, rate0. With enable (bit 6) and start (bit 5) set, the flag clear and both lines high, the block produces a START (SDA pulled low while SCL is released). It then pulls SCL low, clears the start bit, sets the flag (bit 3) and posts 08H.
- R3: While the flag is set after any status other than 38H, scl_oe stays 1.
- R4: When the flag is cleared after a START, the block shifts out the data register MSB first. Bits 7..1 hold the address and bit 0 the direction (1 = read). It samples the ninth slot: with a read address it posts 40H for ACK (SDA low) or 48H for NACK.
- R5: If the block releases SDA for a 1 address bit and samples SDA low, it releases both lines, sets the flag and posts 38H.
- R6: When the flag is cleared after 40H, 50H or 58H with start and stop clear, the block receives 8 bits MSB first into the data register. In the ninth slot it pulls SDA low if ack-enable (bit 2) is 1 and posts 50H, or releases SDA if ack-enable is 0 and posts 58H.
- R7: When the flag is cleared with the stop bit (bit 4) set, the block produces a STOP: SDA is released while SCL is released. It then clears the stop bit, leaves the flag clear, releases both lines and posts F8H.
- R8: When the flag is cleared with the start bit set while the block holds the bus, it produces a repeated START, sets the flag and posts 10H.
- R9: A write address (bit 0 = 0) posts 18H for ACK or 20H for NACK and sets tx_mode. The block then keeps SCL low and starts no byte until start or stop is requested. A read address or a STOP clears tx_mode.
- R10: Serial transfers never change enable, rate2, rate1 or rate0. Writing 1 to the flag bit never sets the flag.
- R11: While enable is 0, both lines are released one cycle later, the flag is cleared and the status reads F8H.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wd | input | 8 | Control register write data |
| dat_we | input | 1 | Data register write strobe |
| dat_wd | input | 8 | Data register write data |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| ctl_q | output | 8 | Control register contents |
| dat_q | output | 8 | Data register contents |
| sta_q | output | 8 | Status code |
| irq | output | 1 | Interrupt flag |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| tx_mode | output | 1 | Set after a write address |

## Verification
The hardest case to reach is a lost address bit. The bit must be released as a 1 by this block while another device holds SDA low, and only during the sampled half of that bit. The bench gets there with its own pull-down on the bus. It asserts the pull-down while the block holds SCL low after reporting 08H and loads an address whose MSB is 1, so the first sampled bit collides. A second awkward case is the wait after a write address: clearing the flag alone must leave the bus frozen. The bench checks this over several hundred cycles before it asks for a repeated START.

// File: rtl/i2c_mrx_seq.sv
module i2c_mrx_seq #(
  parameter int QDIV = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctl_we,
  input  logic [7:0] ctl_wd,
  input  logic       dat_we,
  input  logic [7:0] dat_wd,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic [7:0] ctl_q,
  output logic [7:0] dat_q,
  output logic [7:0] sta_q,
  output logic       irq,
  output logic       scl_oe,
  output logic       sda_oe,
  output logic       tx_mode
);
  localparam int CW = (QDIV > 1) ? $clog2(QDIV) : 1;

  typedef enum logic [2:0] {S_IDLE, S_START, S_HOLD, S_ADDR, S_RX, S_STOP} st_t;

  st_t st;
  logic cr2, en, sta, sto, si, aa, cr1, cr0;
  logic [7:0] dat, sh, sts;
  logic [CW-1:0] tcnt;
  logic [1:0] q;
  logic [3:0] bcnt;
  logic scl_drv, sda_drv, rep, need_addr, tx, rw, ackf;
  logic busy, tick;

  assign busy = (st == S_START) || (st == S_ADDR) || (st == S_RX) || (st == S_STOP);
  assign tick = busy && (tcnt == CW'(QDIV - 1));

  assign ctl_q   = {cr2, en, sta, sto, si, aa, cr1, cr0};
  assign dat_q   = dat;
  assign sta_q   = sts;
  assign irq     = si;
  assign scl_oe  = scl_drv;
  assign sda_oe  = sda_drv;
  assign tx_mode = tx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tcnt <= '0;
    else if (!busy || tick) tcnt <= '0;
    else tcnt <= tcnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {cr2, en, sta, sto, si, aa, cr1, cr0} <= '0;
      dat <= '0; sh <= '0; sts <= 8'hF8;
      st <= S_IDLE; q <= '0; bcnt <= '0;
      scl_drv <= 1'b0; sda_drv <= 1'b0;
      rep <= 1'b0; need_addr <= 1'b0; tx <= 1'b0; rw <= 1'b0; ackf <= 1'b0;
    end else begin
      if (ctl_we) begin
        {cr2, en, sta, sto} <= ctl_wd[7:4];
        {aa, cr1, cr0} <= ctl_wd[2:0];
        if (!ctl_wd[3]) si <= 1'b0;
      end
      if (dat_we) dat <= dat_wd;

      if (!en) begin
        st <= S_IDLE; q <= '0;
        scl_drv <= 1'b0; sda_drv <= 1'b0;
        si <= 1'b0; sts <= 8'hF8; tx <= 1'b0; need_addr <= 1'b0;
      end else begin
        case (st)
          S_IDLE: if (sta && !si && scl_i && sda_i) begin
            st <= S_START; rep <= 1'b0; q <= '0;
          end

          S_HOLD: if (!si) begin
            q <= '0;
            if (sto) st <= S_STOP;
            else if (sta) begin st <= S_START; rep <= 1'b1; end
            else if (need_addr) begin
              st <= S_ADDR; sh <= dat; bcnt <= '0; need_addr <= 1'b0;
            end else if (!tx) begin
              st <= S_RX; bcnt <= '0;
            end
          end

          S_START: if (tick) begin
            q <= q + 2'd1;
            case (q)
              2'd0: sda_drv <= 1'b0;
              2'd1: scl_drv <= 1'b0;
              2'd2: sda_drv <= 1'b1;
              default: begin
                scl_drv <= 1'b1; sta <= 1'b0; si <= 1'b1;
                sts <= rep ? 8'h10 : 8'h08;
                need_addr <= 1'b1; st <= S_HOLD;
              end
            endcase
          end

          S_ADDR, S_RX: if (tick) begin
            q <= q + 2'd1;
            case (q)
              2'd0: begin
                if (bcnt == 4'd8) begin
                  sda_drv <= (st == S_RX) & aa;
                  if (st == S_RX) ackf <= aa;
                end else begin
                  sda_drv <= (st == S_ADDR) & ~sh[7];
                end
              end
              2'd1: scl_drv <= 1'b0;
              2'd2: begin
                if (st == S_ADDR && bcnt < 4'd8 && sh[7] && !sda_i) begin
                  scl_drv <= 1'b0; sda_drv <= 1'b0;
                  si <= 1'b1; sts <= 8'h38; tx <= 1'b0;
                  need_addr <= 1'b0; st <= S_IDLE;
                end else if (bcnt == 4'd8) begin
                  if (st == S_ADDR) ackf <= ~sda_i;
                end else begin
                  if (st == S_ADDR && bcnt == 4'd7) rw <= sh[7];
                  sh <= {sh[6:0], sda_i};
                end
              end
              default: begin
                scl_drv <= 1'b1;
                if (bcnt == 4'd8) begin
                  si <= 1'b1; st <= S_HOLD;
                  if (st == S_RX) begin
                    dat <= sh;
                    sts <= ackf ? 8'h50 : 8'h58;
                  end else begin
                    tx <= ~rw;
                    sts <= rw ? (ackf ? 8'h40 : 8'h48) : (ackf ? 8'h18 : 8'h20);
                  end
                end else begin
                  bcnt <= bcnt + 4'd1;
                end
              end
            endcase
          end

          S_STOP: if (tick) begin
            q <= q + 2'd1;
            case (q)
              2'd0: sda_drv <= 1'b1;
              2'd1: scl_drv <= 1'b0;
              2'd2: sda_drv <= 1'b0;
              default: begin
                sto <= 1'b0; sts <= 8'hF8; tx <= 1'b0;
                need_addr <= 1'b0; st <= S_IDLE;
              end
            endcase
          end

          default: st <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_mrx_seq_chk.sv
module i2c_mrx_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ctl_we,
  input logic [7:0] ctl_q,
  input logic [7:0] sta_q,
  input logic       irq,
  input logic       scl_oe,
  input logic       sda_oe
);
  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(irq) && (sta_q == 8'h08 || sta_q == 8'h10)) |-> !ctl_q[5]) else $error("start bit kept"); // R2

  AST_HOLD_SCL: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && sta_q != 8'h38) |-> scl_oe) else $error("bus not held"); // R3

  AST_ARB_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && sta_q == 8'h38) |-> (!scl_oe && !sda_oe)) else $error("lines held after loss"); // R5

  AST_STOP_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ctl_q[6]) && ctl_q[6] && sta_q == 8'hF8 && $past(sta_q) != 8'hF8)
      |-> (!ctl_q[4] && !irq && !scl_oe && !sda_oe)) else $error("stop end wrong"); // R7

  AST_CFG_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(ctl_we) |-> ({ctl_q[7:6], ctl_q[1:0]} == $past({ctl_q[7:6], ctl_q[1:0]}))) else $error("config bits moved"); // R10

  AST_DISABLE_REL: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(ctl_q[6]) |-> (!scl_oe && !sda_oe && !irq && sta_q == 8'hF8)) else $error("disabled block active"); // R11
endmodule

bind i2c_mrx_seq i2c_mrx_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_q(ctl_q), .sta_q(sta_q),
  .irq(irq), .scl_oe(scl_oe), .sda_oe(sda_oe)
);

// File: tb/i2c_mrx_seq_bench.sv
module i2c_mrx_seq_bench;
  localparam logic [7:0] STA = 8'h20, STO = 8'h10, SIB = 8'h08, AA = 8'h04, BASE = 8'hC1;
  localparam logic [6:0] SADDR = 7'h50;

  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic ctl_we = 1'b0, dat_we = 1'b0;
  logic [7:0] ctl_wd = 8'h00, dat_wd = 8'h00;
  logic [7:0] ctl_q, dat_q, sta_q;
  logic irq, scl_oe, sda_oe, tx_mode;
  logic sl_low = 1'b0, rogue = 1'b0, done = 1'b0;
  logic scl_bus, sda_bus;
  assign scl_bus = ~scl_oe;
  assign sda_bus = ~(sda_oe | sl_low | rogue);
  int errs = 0, checks = 0;

  i2c_mrx_seq #(.QDIV(4)) u_i2c_mrx_seq (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wd(ctl_wd),
    .dat_we(dat_we), .dat_wd(dat_wd), .scl_i(scl_bus), .sda_i(sda_bus),
    .ctl_q(ctl_q), .dat_q(dat_q), .sta_q(sta_q), .irq(irq),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .tx_mode(tx_mode)
  );

  function automatic logic [7:0] sbyte(int i);
    return 8'h96 ^ 8'(i * 43);
  endfunction

  // behavioural slave transmitter
  logic pscl = 1'b1, psda = 1'b1, match = 1'b0, mack = 1'b0;
  logic [7:0] ash = 8'h00, tbyte;
  int sm = 0, bn = 0, bidx = 0;
  always @(negedge clk) begin
    if (pscl && scl_bus && psda && !sda_bus) begin sm = 1; bn = 0; sl_low = 1'b0; end
    else if (pscl && scl_bus && !psda && sda_bus) begin sm = 0; sl_low = 1'b0; end
    else if (!pscl && scl_bus) begin
      if (sm == 1) begin if (bn < 8) ash = {ash[6:0], sda_bus}; bn++; end
      else if (sm == 2) begin if (bn == 8) mack = !sda_bus; bn++; end
    end else if (pscl && !scl_bus) begin
      if (sm == 1) begin
        if (bn == 8) begin match = (ash[7:1] == SADDR); sl_low = match; end
        else if (bn == 9) begin
          sl_low = 1'b0;
          if (match && ash[0]) begin sm = 2; bidx = 0; bn = 0; tbyte = sbyte(0); sl_low = ~tbyte[7]; end
          else sm = 0;
        end
      end else if (sm == 2) begin
        if (bn < 8) begin tbyte = sbyte(bidx); sl_low = ~tbyte[7-bn]; end
        else if (bn == 8) sl_low = 1'b0;
        else if (mack) begin bidx++; bn = 0; tbyte = sbyte(bidx); sl_low = ~tbyte[7]; end
        else begin sm = 0; sl_low = 1'b0; end
      end
    end
    pscl = scl_bus; psda = sda_bus;
  end

  task automatic chk(string r, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin errs++; $display("FAIL %s actual=%h expected=%h", r, act, exp); end
  endtask

  task automatic wr_ctl(logic [7:0] v);
    @(negedge clk); ctl_we = 1'b1; ctl_wd = v;
    @(negedge clk); ctl_we = 1'b0;
  endtask

  task automatic wr_dat(logic [7:0] v);
    @(negedge clk); dat_we = 1'b1; dat_wd = v;
    @(negedge clk); dat_we = 1'b0;
  endtask

  task automatic wait_irq(string r);
    int n = 0;
    while (irq !== 1'b1 && n < 3000) begin @(negedge clk); n++; end
    if (n >= 3000) begin checks++; errs++; $display("FAIL %s actual=no-flag expected=flag", r); end
  endtask

  task automatic wait_idle(string r);
    int n = 0;
    while (sta_q !== 8'hF8 && n < 3000) begin @(negedge clk); n++; end
    if (n >= 3000) begin checks++; errs++; $display("FAIL %s actual=%h expected=f8", r, sta_q); end
  endtask

  task automatic do_stop();
    wr_ctl(BASE | STO);
    wait_idle("R7 stop");
    chk("R7 stop bit cleared", {7'b0, ctl_q[4]}, 8'h00);
    chk("R7 flag clear, lines free", {5'b0, irq, scl_oe, sda_oe}, 8'h00);
    chk("R10 config bits kept", ctl_q & 8'hC3, BASE);
    chk("R9 tx_mode off after stop", {7'b0, tx_mode}, 8'h00);
  endtask

  task automatic do_start(logic [7:0] exp, string r);
    wr_ctl(BASE | STA | AA);
    wait_irq(r);
    chk(r, sta_q, exp);
    chk("R2 start bit cleared", {7'b0, ctl_q[5]}, 8'h00);
    chk("R3 scl held", {7'b0, scl_oe}, 8'h01);
  endtask

  task automatic do_read(int n);
    do_start(8'h08, "R2 start status");
    repeat (100) @(negedge clk);
    chk("R3 still held after wait", {sta_q[7:1], scl_oe}, 8'h09);
    wr_dat({SADDR, 1'b1});
    wr_ctl(BASE | AA);
    wait_irq("R4 addr");
    chk("R4 read addr ack", sta_q, 8'h40);
    chk("R9 tx_mode off for read", {7'b0, tx_mode}, 8'h00);
    for (int i = 0; i < n; i++) begin
      wr_ctl((i < n - 1) ? (BASE | AA) : BASE);
      wait_irq("R6 byte");
      chk("R6 byte status", sta_q, (i < n - 1) ? 8'h50 : 8'h58);
      chk("R6 byte data", dat_q, sbyte(i));
    end
    do_stop();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 ctl", ctl_q, 8'h00);
    chk("R1 dat", dat_q, 8'h00);
    chk("R1 status", sta_q, 8'hF8);
    chk("R1 outputs", {4'b0, irq, scl_oe, sda_oe, tx_mode}, 8'h00);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    wr_ctl(BASE | SIB);
    repeat (3) @(negedge clk);
    chk("R10 flag not settable", {7'b0, irq}, 8'h00);

    for (int n = 1; n <= 4; n++) do_read(n);

    // unmatched address -> NACK
    do_start(8'h08, "R2 start status");
    wr_dat({7'h3D, 1'b1});
    wr_ctl(BASE | AA);
    wait_irq("R4 nack");
    chk("R4 read addr nack", sta_q, 8'h48);
    do_stop();

    // write address, wait, repeated start, read
    do_start(8'h08, "R2 start status");
    wr_dat({SADDR, 1'b0});
    wr_ctl(BASE | AA);
    wait_irq("R9 write addr");
    chk("R9 write addr ack", sta_q, 8'h18);
    chk("R9 tx_mode set", {7'b0, tx_mode}, 8'h01);
    wr_ctl(BASE | AA);
    repeat (300) @(negedge clk);
    chk("R9 waits for start/stop", {sta_q[7:2], irq, scl_oe}, 8'h19);
    do_start(8'h10, "R8 repeated start");
    chk("R9 tx_mode kept", {7'b0, tx_mode}, 8'h01);
    wr_dat({SADDR, 1'b1});
    wr_ctl(BASE | AA);
    wait_irq("R4 addr");
    chk("R4 read addr ack", sta_q, 8'h40);
    chk("R9 tx_mode cleared by read", {7'b0, tx_mode}, 8'h00);
    wr_ctl(BASE);
    wait_irq("R6 byte");
    chk("R6 nack byte", sta_q, 8'h58);
    chk("R6 byte data", dat_q, sbyte(0));
    // repeated start after a NACKed byte
    do_start(8'h10, "R8 repeated start after byte");
    do_stop();

    // arbitration loss on first address bit
    do_start(8'h08, "R2 start status");
    rogue = 1'b1;
    wr_dat({SADDR, 1'b1});
    wr_ctl(BASE | AA);
    wait_irq("R5 lost");
    chk("R5 lost status", sta_q, 8'h38);
    chk("R5 lines released", {6'b0, scl_oe, sda_oe}, 8'h00);
    rogue = 1'b0;
    wr_ctl(BASE | AA);
    chk("R5 flag cleared", {7'b0, irq}, 8'h00);

    // disable during a held transfer
    do_start(8'h08, "R2 start status");
    wr_dat({SADDR, 1'b1});
    wr_ctl(BASE | AA);
    wait_irq("R4 addr");
    wr_ctl(8'h81 | AA);
    @(negedge clk);
    chk("R11 disabled", {sta_q[7:3], irq, scl_oe, sda_oe}, 8'hF8);
    wr_ctl(BASE);
    repeat (5) @(negedge clk);
    chk("R11 idle after enable", sta_q, 8'hF8);

    do_read(2);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errs++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule